// File: doc/BRIEF.md
# Programmable-Sense Interrupt Controller

This block gathers 32 raw interrupt lines into one sticky pending register and forwards them to a processor as two interrupt outputs. Every source has its own sense setting: level or edge, and active low or active high. Every source is also routed to either the normal output or the critical (machine-check style) output. Software controls the block through a small synchronous register bus. Through that bus it can:

- acknowledge pending bits by writing ones;
- mask sources;
- read the masked pending set;
- read the index of the highest-priority pending source.

Raw lines pass through a two-flop synchroniser before sense detection. An edge-sensitive source compares the synchronised value with its value one cycle earlier. A level-sensitive source sets its pending bit for as long as its line is active, so it comes back at once after a clear if the line is still active. Source numbers map to register bits most-significant first, and source 0 has the highest priority. Sources 17, 18 and 19 are reserved and never become pending.

Top module: `uic_top`

## Requirements
- R1: Word addresses are: 0 pending status, 1 enable, 2 route, 3 polarity, 4 trigger, 5 masked status (read only), 6 highest pending (read only). The read data register returns the selected word one clock after the address is applied. Writes take effect on the clock edge where the write enable is high.
- R2: Source n occupies bit (31 − n) of every per-source register, so source 0 is bit 31 and source 31 is bit 0.
- R3: Writing 1 to a bit of address 0 clears that pending bit. Writing 0 leaves the bit unchanged.
- R4: With trigger bit 0 the source is level-sensitive: its pending bit is set on every cycle its synchronised line is active. A clear while the line is still active is therefore undone.
- R5: With trigger bit 1 the source is edge-sensitive and sets pending only on a transition of the synchronised line. A rising transition counts when polarity is 1, and a falling one counts when polarity is 0. A line held steady never sets pending again.
- R6: Polarity bit 0 means the line is active when low. Polarity bit 1 means the line is active when high.
- R7: A pending bit stays set after its line goes inactive until software clears it.
- R8: Masked status equals pending AND enable. Only masked bits can drive an output.
- R9: A masked source whose route bit is 1 drives `irq_norm`, and one whose route bit is 0 drives `irq_crit`. Both outputs are registered.
- R10: Address 6 returns bit 31 = valid and bits 4:0 = the lowest-numbered source with a masked bit set. When no masked bit is set it returns all zero.
- R11: Sources 17 to 19 (bits 14 to 12) never become pending and never assert an output.
- R12: After reset, pending, enable, polarity and trigger are all zero and route is all ones. Both outputs and the highest-pending word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 32 | Raw interrupt lines, source n on bit 31−n |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
A vector table drives the same block with six patterns:

- a single top-priority source on a level-sensitive, active-low line;
- the lowest-priority source on an edge-sensitive, active-high line routed critical;
- a mixed word with alternating polarity and half the sources on edges;
- a reserved-plus-ordinary pattern;
- an all-active pattern with nothing enabled;
- a scattered pattern with interleaved trigger and route settings.

Between them these separate a wrong bit ordering from a wrong priority direction, and masking faults from routing faults. Directed sequences then cover the remaining behaviour:

- They contrast a level source held active across a clear, which must come back, with an edge source held across a clear, which must not.
- They switch the active edge of one source between rising and falling.
- They confirm that a write of zeros, a short pulse that has ended, and activity on a reserved line each leave the outputs as the requirements predict.

// File: rtl/uic_pkg.sv
`timescale 1ns/1ps
package uic_pkg;
  typedef enum logic [2:0] {
    REG_STAT  = 3'd0,
    REG_EN    = 3'd1,
    REG_ROUTE = 3'd2,
    REG_POL   = 3'd3,
    REG_TRIG  = 3'd4,
    REG_MSTAT = 3'd5,
    REG_HIGH  = 3'd6
  } uic_reg_e;
endpackage

// File: rtl/uic_sync.sv
`timescale 1ns/1ps
module uic_sync #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/uic_sense.sv
`timescale 1ns/1ps
module uic_sense #(
  parameter int          N       = 32,
  parameter logic [N-1:0] RSVD    = '0,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_s,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status_q
);
  logic [N-1:0] line_d;
  logic [N-1:0] set_v;

  always_ff @(posedge clk) begin
    if (rst) line_d <= RST_VAL;
    else     line_d <= line_s;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (RSVD[i]) begin : g_rsvd
      assign set_v[i] = 1'b0;
    end else begin : g_live
      logic lvl_hit, edg_hit;
      always_comb begin
        lvl_hit  = (line_s[i] == pol[i]);
        edg_hit  = pol[i] ? (line_s[i] & ~line_d[i]) : (~line_s[i] & line_d[i]);
        set_v[i] = trig[i] ? edg_hit : lvl_hit;
      end

      assert_edge_transition_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(status_q[i]) && $past(trig[i])) |-> $past(line_s[i] != line_d[i]));

      assert_level_active_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(status_q[i]) && !$past(trig[i])) |-> $past(line_s[i] == pol[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr) | set_v;
  end

  assert_rsvd_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (status_q & RSVD) == '0);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(status_q) & ~$past(clr) & ~status_q) == '0);
endmodule

// File: rtl/uic_prio.sv
`timescale 1ns/1ps
module uic_prio #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     masked,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int b = 0; b < N; b++) begin
      if (masked[b]) begin
        valid = 1'b1;
        idx   = IDX_W'(N - 1 - b);
      end
    end
  end
endmodule

// File: rtl/uic_top.sv
`timescale 1ns/1ps
module uic_top #(
  parameter int                 NUM_SRC  = 32,
  parameter int                 ADDR_W   = 3,
  parameter logic [NUM_SRC-1:0] RSVD_MAP = 32'h0000_7000,
  parameter logic [NUM_SRC-1:0] IN_IDLE  = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               irq_norm,
  output logic               irq_crit
);
  import uic_pkg::*;

  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] en_q, route_q, pol_q, trig_q;
  logic [NUM_SRC-1:0] line_s, status_q, clr_v, masked_w, hp_word;
  logic               hp_valid;
  logic [IDX_W-1:0]   hp_idx;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input uic_reg_e r);
    return a == ADDR_W'(r);
  endfunction

  uic_sync #(.W(NUM_SRC), .RST_VAL(IN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(line_s)
  );

  assign clr_v = (bus_we && hit(bus_addr, REG_STAT)) ? bus_wdata : '0;

  uic_sense #(.N(NUM_SRC), .RSVD(RSVD_MAP), .RST_VAL(IN_IDLE)) u_sense (
    .clk(clk), .rst(rst), .line_s(line_s), .trig(trig_q), .pol(pol_q),
    .clr(clr_v), .status_q(status_q)
  );

  assign masked_w = status_q & en_q;

  uic_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .masked(masked_w), .valid(hp_valid), .idx(hp_idx)
  );

  always_comb begin
    hp_word              = '0;
    hp_word[NUM_SRC-1]   = hp_valid;
    hp_word[IDX_W-1:0]   = hp_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      route_q <= '1;
      pol_q   <= '0;
      trig_q  <= '0;
    end else if (bus_we) begin
      if (hit(bus_addr, REG_EN))    en_q    <= bus_wdata;
      if (hit(bus_addr, REG_ROUTE)) route_q <= bus_wdata;
      if (hit(bus_addr, REG_POL))   pol_q   <= bus_wdata;
      if (hit(bus_addr, REG_TRIG))  trig_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_norm  <= 1'b0;
      irq_crit  <= 1'b0;
    end else begin
      irq_norm <= |(masked_w & route_q);
      irq_crit <= |(masked_w & ~route_q);
      case (bus_addr)
        ADDR_W'(REG_STAT):  bus_rdata <= status_q;
        ADDR_W'(REG_EN):    bus_rdata <= en_q;
        ADDR_W'(REG_ROUTE): bus_rdata <= route_q;
        ADDR_W'(REG_POL):   bus_rdata <= pol_q;
        ADDR_W'(REG_TRIG):  bus_rdata <= trig_q;
        ADDR_W'(REG_MSTAT): bus_rdata <= masked_w;
        ADDR_W'(REG_HIGH):  bus_rdata <= hp_word;
        default:            bus_rdata <= '0;
      endcase
    end
  end

  assert_norm_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq_norm |-> $past(|(status_q & en_q & route_q)));

  assert_crit_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq_crit |-> $past(|(status_q & en_q & ~route_q)));

  assert_mask_read_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(REG_MSTAT)) |-> ((bus_rdata & ~$past(en_q)) == '0));

  assert_hp_lowest_R10: assert property (@(posedge clk) disable iff (rst)
    hp_valid |-> (masked_w[NUM_SRC-1-int'(hp_idx)] &&
                  ((masked_w >> (NUM_SRC - int'(hp_idx))) == '0)));

  assert_hp_empty_R10: assert property (@(posedge clk) disable iff (rst)
    !hp_valid |-> (masked_w == '0));
endmodule

// File: tb/sim_uic_top.sv
`timescale 1ns/1ps
module sim_uic_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '1;
  logic        irq_norm, irq_crit;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [31:0] RSVD = 32'h0000_7000;
  localparam int NV = 6;
  localparam logic [31:0] V_PAT  [NV] = '{32'h8000_0000, 32'h0000_0001, 32'h0F0F_00F0,
                                          32'h0000_7800, 32'hFFFF_FFFF, 32'h1234_5678};
  localparam logic [31:0] V_EN   [NV] = '{32'hFFFF_FFFF, 32'h0000_0001, 32'h00FF_FFFF,
                                          32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] V_TRIG [NV] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_0000,
                                          32'h0000_0000, 32'h5555_5555, 32'h0F0F_0F0F};
  localparam logic [31:0] V_POL  [NV] = '{32'h0000_0000, 32'h0000_0001, 32'hAAAA_5555,
                                          32'h0000_0000, 32'hFFFF_0000, 32'hFF00_FF00};
  localparam logic [31:0] V_ROUTE[NV] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_FF00,
                                          32'hFFFF_FFFF, 32'h0000_0000, 32'h00FF_00FF};

  uic_top u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_norm(irq_norm), .irq_crit(irq_crit)
  );

  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_hp(input logic [31:0] m);
    for (int n = 0; n < 32; n++)
      if (m[31-n]) return {1'b1, 26'd0, 5'(n)};
    return 32'h0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog R12 actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, m;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R12 / R1: reset values read through the bus
    rd(3'd0, d); check(d == 32'h0, "R12 status", d, 32'h0);
    rd(3'd1, d); check(d == 32'h0, "R12 enable", d, 32'h0);
    rd(3'd2, d); check(d == 32'hFFFF_FFFF, "R12 route", d, 32'hFFFF_FFFF);
    rd(3'd3, d); check(d == 32'h0, "R12 polarity", d, 32'h0);
    rd(3'd4, d); check(d == 32'h0, "R12 trigger", d, 32'h0);
    rd(3'd6, d); check(d == 32'h0, "R12 highest", d, 32'h0);
    check(!irq_norm && !irq_crit, "R12 outputs", {30'd0, irq_norm, irq_crit}, 32'h0);

    // Vector table: R2 R6 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      wr(3'd4, V_TRIG[v]);
      wr(3'd3, V_POL[v]);
      wr(3'd1, V_EN[v]);
      wr(3'd2, V_ROUTE[v]);
      irq_in = ~V_POL[v];
      settle();
      wr(3'd0, 32'hFFFF_FFFF);
      settle();
      irq_in = ~(V_PAT[v] ^ V_POL[v]);
      settle();
      m = V_PAT[v] & V_EN[v] & ~RSVD;
      rd(3'd5, d); check(d == m, "R8 R2 R6 masked status", d, m);
      rd(3'd6, d); check(d == exp_hp(m), "R10 highest pending", d, exp_hp(m));
      check(irq_norm == |(m & V_ROUTE[v]), "R9 normal output", 32'(irq_norm),
            32'(|(m & V_ROUTE[v])));
      check(irq_crit == |(m & ~V_ROUTE[v]), "R9 critical output", 32'(irq_crit),
            32'(|(m & ~V_ROUTE[v])));
    end

    // Directed: level source 5 (bit 26), active low
    wr(3'd4, 32'h0); wr(3'd3, 32'h0); wr(3'd1, 32'hFFFF_FFFF); wr(3'd2, 32'hFFFF_FFFF);
    irq_in = '1; settle(); wr(3'd0, 32'hFFFF_FFFF); settle();
    irq_in[26] = 1'b0; repeat (3) @(negedge clk); irq_in[26] = 1'b1; settle();
    rd(3'd0, d); check(d == 32'h0400_0000, "R7 sticky after pulse", d, 32'h0400_0000);
    wr(3'd0, 32'h0); rd(3'd0, d);
    check(d == 32'h0400_0000, "R3 write zero no effect", d, 32'h0400_0000);
    wr(3'd0, 32'h0400_0000); rd(3'd0, d);
    check(d == 32'h0, "R3 write one clears", d, 32'h0);
    irq_in[26] = 1'b0; settle(); wr(3'd0, 32'h0400_0000); settle();
    rd(3'd0, d); check(d == 32'h0400_0000, "R4 level reasserts", d, 32'h0400_0000);
    irq_in[26] = 1'b1; settle(); wr(3'd0, 32'hFFFF_FFFF); settle();
    rd(3'd0, d); check(d == 32'h0, "R4 clears once inactive", d, 32'h0);

    // Directed: edge source 5, rising then falling
    wr(3'd4, 32'h0400_0000); wr(3'd3, 32'h0400_0000);
    irq_in[26] = 1'b0; settle(); wr(3'd0, 32'hFFFF_FFFF); settle();
    irq_in[26] = 1'b1; settle();
    rd(3'd0, d); check(d == 32'h0400_0000, "R5 rising edge sets", d, 32'h0400_0000);
    wr(3'd0, 32'h0400_0000); settle();
    rd(3'd0, d); check(d == 32'h0, "R5 held level no retrigger", d, 32'h0);
    irq_in[26] = 1'b0; settle();
    rd(3'd0, d); check(d == 32'h0, "R5 falling ignored when rising", d, 32'h0);
    wr(3'd3, 32'h0); irq_in[26] = 1'b1; settle(); wr(3'd0, 32'hFFFF_FFFF); settle();
    rd(3'd0, d); check(d == 32'h0, "R5 rising ignored when falling", d, 32'h0);
    irq_in[26] = 1'b0; settle();
    rd(3'd0, d); check(d == 32'h0400_0000, "R5 falling edge sets", d, 32'h0400_0000);

    // Directed: reserved source 17 (bit 14), level active low, enabled
    wr(3'd4, 32'h0); irq_in = '1; settle(); wr(3'd0, 32'hFFFF_FFFF); settle();
    irq_in[14] = 1'b0; settle();
    rd(3'd0, d); check(d == 32'h0, "R11 reserved never pending", d, 32'h0);
    check(!irq_norm && !irq_crit, "R11 reserved no output", {30'd0, irq_norm, irq_crit}, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, d); check(d == 32'h0, "R1 R10 highest read only", d, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule